// File: doc/BRIEF.md
# Programmable Counter/Timer Channel with Pulse Output

This block is one channel of a 32-bit counter/timer. Its count advances on a tick taken from the system clock, from the rising edge of an external clock pin, or from the rising edge of the previous channel's pulse output. A gate input, read according to a selectable gate type, decides whether the channel counts, which direction it counts in, or when a single pulse is fired.

The counter always counts up from a loaded start value toward rollover. When it wraps to zero it spends one tick there, which is the terminal count, and then reloads the start value. A width register sets the count at which the output turns active. The output stays active until the wrap, so the start value fixes the output period and the width value fixes where the active part begins. Software loads the start value, the width value and a control word. It reads back the live count and a two-bit status.

The control word is 9 bits wide:
- bits [1:0] select the mode: 0 free count, 1 up/down, 2 single shot, 3 repeating shot.
- bit 2 selects active-low output.
- bits [5:3] select the gate type: 0 software (always on), 1 high level, 2 low level, 3 rising edge, 4 falling edge; values 5 to 7 act as 0.
- bits [7:6] select the clock source: 0 internal, 1 external pin, 2 previous channel.
- bit 8 arms the shot trigger.

Top module: `ctr_pulse_chan`

## Requirements
- R1: A write to the start register loads the counter in the same clock edge, and `count_q` always shows the live count. Reset (`rst_n` low at a clock edge) clears the counter, the start value, the width value, the control word and the status.
- R2: In free count mode, each tick that meets an enabled gate adds one to the counter, so the number of events counted equals `count_q` minus the start value.
- R3: After the count 0xFFFFFFFF comes 0 for one tick, and then the start value P. One output period is therefore 0xFFFFFFFF + 2 − P ticks long, for example 3 ticks when P = 0xFFFFFFFE.
- R4: The output is active while the count is non-zero and at least the width value, in free count mode or during a shot. It is inactive in up/down mode. Control bit 2 = 0 makes the active level 1; bit 2 = 1 makes the active level 0.
- R5: In free count mode the gate enables counting. Type 0 always enables it. Types 1 and 3 enable it while the gate pin is high. Types 2 and 4 enable it while the pin is low.
- R6: In up/down mode the counter adds one per tick when the gate is in its enabling state (as in R5) and subtracts one otherwise. Type 2 therefore reverses the sense of type 1.
- R7: Clock source 0 ticks every cycle. Source 1 ticks once per rising edge of `ext_clk_in`, after a two-stage synchroniser. Source 2 ticks once per rising edge of `casc_clk_in`, with no synchroniser.
- R8: In single shot mode with bit 8 set, the gate's trigger edge starts one pulse: rising for types 1 and 3, falling for types 2 and 4. While disarmed or waiting, the counter holds its value. At the terminal count the counter reloads and the channel disarms. Later gate edges are then ignored until the control word is written again.
- R9: In repeating shot mode, each trigger edge fires one pulse and the channel stays armed after the reload. Trigger edges that arrive during a pulse are ignored.
- R10: Status bit 1 (shot running) clears at the end of a pulse and also when the start register is written. Status bit 0 shows the armed state. A start-register write takes priority over a tick that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| ext_gate_in | input | 1 | External gate, asynchronous |
| casc_clk_in | input | 1 | Pulse output of the previous channel, synchronous |
| period_wr | input | 1 | Write strobe for the start register |
| period_data | input | WIDTH | Start value |
| width_wr | input | 1 | Write strobe for the width register |
| width_data | input | WIDTH | Width (active-from) count |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_data | input | 9 | Control word, layout as above |
| count_q | output | WIDTH | Live counter value |
| pulse_out | output | 1 | Pulse output, polarity applied |
| status | output | 2 | {shot running, armed} |

## Verification
A start-register write and a counting tick can fall in the same cycle, and the same holds for a write and the end of a running shot. With the internal clock selected, every cycle is a tick. Each stimulus vector therefore writes the start value while the counter is running and expects the counter to equal the written value exactly one edge later, with no added increment. A second case writes the start register while a repeating shot is running. The running flag must drop on that same edge and the count must equal the new start value.

// File: rtl/ctr_pkg.sv
// Shared types for the counter/timer channel: mode, gate type, clock
// source and the packed control word. Assumes a 9-bit control word.
package ctr_pkg;
    typedef enum logic [1:0] {
        MODE_COUNT   = 2'd0,
        MODE_UPDN    = 2'd1,
        MODE_ONESHOT = 2'd2,
        MODE_REPEAT  = 2'd3
    } ctr_mode_e;

    typedef enum logic [2:0] {
        GATE_SW   = 3'd0,
        GATE_HIGH = 3'd1,
        GATE_LOW  = 3'd2,
        GATE_RISE = 3'd3,
        GATE_FALL = 3'd4
    } gate_e;

    typedef enum logic [1:0] {
        CLK_INT  = 2'd0,
        CLK_EXT  = 2'd1,
        CLK_CASC = 2'd2
    } clk_src_e;

    typedef struct packed {
        logic      trig_en;
        clk_src_e  src;
        gate_e     gate;
        logic      pol_low;
        ctr_mode_e mode;
    } ctr_ctrl_t;

    localparam int CTRL_W = $bits(ctr_ctrl_t);
endpackage

// File: rtl/ctr_sync_edge.sv
// Optional synchroniser followed by a change detector.
// STAGES = 0 passes the input through, for sources already in the clk
// domain. Outputs the settled level and a one-cycle pulse on any change.
module ctr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic toggled
);
    logic prev_q;

    generate
        if (STAGES == 0) begin : g_direct
            assign level = din;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            // Shift the asynchronous input through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= (sh_q << 1) | STAGES'(din);
            end
            assign level = sh_q[STAGES-1];
        end
    endgenerate

    // Remember the previous settled level for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign toggled = level ^ prev_q;
endmodule

// File: rtl/ctr_gate_logic.sv
// Interprets the settled gate according to the gate type. Produces the
// count enable, the up/down direction and the shot trigger. Purely
// combinational.
module ctr_gate_logic
    import ctr_pkg::*;
(
    input  gate_e gate_type,
    input  logic  g_level,
    input  logic  g_toggled,
    output logic  count_en,
    output logic  dir_up,
    output logic  trigger
);
    // Map gate type to enable, direction and trigger edge
    always_comb begin
        case (gate_type)
            GATE_HIGH, GATE_RISE: begin
                count_en = g_level;
                trigger  = g_level & g_toggled;
            end
            GATE_LOW, GATE_FALL: begin
                count_en = ~g_level;
                trigger  = ~g_level & g_toggled;
            end
            default: begin
                count_en = 1'b1;
                trigger  = 1'b1;
            end
        endcase
        dir_up = count_en;
    end
endmodule

// File: rtl/ctr_core.sv
// Counter datapath and shot state. Counts up toward rollover, spends one
// tick at zero, then reloads the start value. A start-register write
// outranks every other update; a control write re-arms and ends a shot.
module ctr_core
    import ctr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_wr,
    input  logic [WIDTH-1:0] period_data,
    input  logic [WIDTH-1:0] period_q,
    input  logic             ctrl_wr,
    input  logic             trig_en_new,
    input  ctr_mode_e        mode,
    input  logic             tick,
    input  logic             count_en,
    input  logic             dir_up,
    input  logic             trigger,
    output logic [WIDTH-1:0] cnt_q,
    output logic             busy_q,
    output logic             armed_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic at_zero;
    assign at_zero = (cnt_q == '0);

    // Advance, reload or load the counter and track the shot state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (period_wr) begin
                cnt_q  <= period_data;
                busy_q <= 1'b0;
            end else begin
                case (mode)
                    MODE_COUNT: begin
                        if (tick && count_en)
                            cnt_q <= at_zero ? period_q : cnt_q + ONE;
                    end
                    MODE_UPDN: begin
                        if (tick)
                            cnt_q <= dir_up ? cnt_q + ONE : cnt_q - ONE;
                    end
                    default: begin
                        if (busy_q) begin
                            if (tick) begin
                                if (at_zero) begin
                                    cnt_q  <= period_q;
                                    busy_q <= 1'b0;
                                    if (mode == MODE_ONESHOT) armed_q <= 1'b0;
                                end else begin
                                    cnt_q <= cnt_q + ONE;
                                end
                            end
                        end else if (armed_q && trigger) begin
                            busy_q <= 1'b1;
                        end
                    end
                endcase
            end
            if (ctrl_wr) begin
                armed_q <= trig_en_new;
                busy_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ctr_pulse_chan.sv
// One counter/timer channel: holds the start, width and control registers,
// selects the tick source and forms the polarised pulse output.
// Assumes casc_clk_in already lies in the clk domain.
module ctr_pulse_chan
    import ctr_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_in,
    input  logic              ext_gate_in,
    input  logic              casc_clk_in,
    input  logic              period_wr,
    input  logic [WIDTH-1:0]  period_data,
    input  logic              width_wr,
    input  logic [WIDTH-1:0]  width_data,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_data,
    output logic [WIDTH-1:0]  count_q,
    output logic              pulse_out,
    output logic [1:0]        status
);
    logic [WIDTH-1:0] period_q, width_q, cnt;
    ctr_ctrl_t        ctrl_q, ctrl_new;
    logic             ck_lvl, ck_tog, cs_lvl, cs_tog, g_lvl, g_tog;
    logic             tick, count_en, dir_up, trigger, busy, armed, active;
    ctr_mode_e        mode_w;
    logic             pol_w;

    assign ctrl_new = ctr_ctrl_t'(ctrl_data);
    assign mode_w   = ctrl_q.mode;
    assign pol_w    = ctrl_q.pol_low;

    // Hold the software-written start, width and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            width_q  <= '0;
            ctrl_q   <= '0;
        end else begin
            if (period_wr) period_q <= period_data;
            if (width_wr)  width_q  <= width_data;
            if (ctrl_wr)   ctrl_q   <= ctrl_new;
        end
    end

    ctr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_clk (
        .clk(clk), .rst_n(rst_n), .din(ext_clk_in), .level(ck_lvl), .toggled(ck_tog));
    ctr_sync_edge #(.STAGES(0)) u_casc_clk (
        .clk(clk), .rst_n(rst_n), .din(casc_clk_in), .level(cs_lvl), .toggled(cs_tog));
    ctr_sync_edge #(.STAGES(SYNC_STAGES)) u_gate (
        .clk(clk), .rst_n(rst_n), .din(ext_gate_in), .level(g_lvl), .toggled(g_tog));

    // Pick the tick from the selected clock source
    always_comb begin
        case (ctrl_q.src)
            CLK_INT:  tick = 1'b1;
            CLK_EXT:  tick = ck_lvl & ck_tog;
            CLK_CASC: tick = cs_lvl & cs_tog;
            default:  tick = 1'b0;
        endcase
    end

    ctr_gate_logic u_gate_logic (
        .gate_type(ctrl_q.gate), .g_level(g_lvl), .g_toggled(g_tog),
        .count_en(count_en), .dir_up(dir_up), .trigger(trigger));

    ctr_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n),
        .period_wr(period_wr), .period_data(period_data), .period_q(period_q),
        .ctrl_wr(ctrl_wr), .trig_en_new(ctrl_new.trig_en), .mode(ctrl_q.mode),
        .tick(tick), .count_en(count_en), .dir_up(dir_up), .trigger(trigger),
        .cnt_q(cnt), .busy_q(busy), .armed_q(armed));

    // Output is active from the width match until the wrap to zero
    always_comb begin
        active = (cnt != '0) && (cnt >= width_q) &&
                 ((ctrl_q.mode == MODE_COUNT) ||
                  (((ctrl_q.mode == MODE_ONESHOT) || (ctrl_q.mode == MODE_REPEAT)) && busy));
    end

    assign pulse_out = active ^ ctrl_q.pol_low;
    assign count_q   = cnt;
    assign status    = {busy, armed};
endmodule

// File: rtl/ctr_pulse_chan_chk.sv
// Property checker for ctr_pulse_chan, attached by bind below.
module ctr_pulse_chan_chk
    import ctr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_wr,
    input logic [WIDTH-1:0] period_data,
    input logic [WIDTH-1:0] count_q,
    input logic             pulse_out,
    input logic [1:0]       status,
    input ctr_mode_e        mode,
    input logic             pol_low
);
    AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> count_q == $past(period_data)); // R1

    AST_ZERO_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> pulse_out == pol_low); // R4

    AST_UPDN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDN) |-> pulse_out == pol_low); // R4

    AST_UPDN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UPDN && !period_wr) |=>
        (count_q == $past(count_q) || count_q == $past(count_q) + WIDTH'(1) ||
         count_q == $past(count_q) - WIDTH'(1))); // R6

    AST_SHOT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_ONESHOT || mode == MODE_REPEAT) && !status[1] && !period_wr)
        |=> $stable(count_q)); // R8

    AST_WR_ENDS_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> !status[1]); // R10
endmodule

bind ctr_pulse_chan ctr_pulse_chan_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .period_wr(period_wr), .period_data(period_data),
    .count_q(count_q), .pulse_out(pulse_out), .status(status),
    .mode(mode_w), .pol_low(pol_w));

// File: tb/tb_ctr_pulse_chan.sv
module tb_ctr_pulse_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_in = 1'b0, ext_gate_in = 1'b0, casc_clk_in = 1'b0;
    logic        period_wr = 1'b0, width_wr = 1'b0, ctrl_wr = 1'b0;
    logic [31:0] period_data = '0, width_data = '0;
    logic [8:0]  ctrl_data = '0;
    logic [31:0] count_q;
    logic        pulse_out;
    logic [1:0]  status;
    int          checks = 0, fails = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    ctr_pulse_chan dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .ext_gate_in(ext_gate_in),
        .casc_clk_in(casc_clk_in), .period_wr(period_wr), .period_data(period_data),
        .width_wr(width_wr), .width_data(width_data), .ctrl_wr(ctrl_wr),
        .ctrl_data(ctrl_data), .count_q(count_q), .pulse_out(pulse_out), .status(status));

    // Vectors: free count, internal clock, software gate, active high
    localparam int NV = 8;
    localparam logic [31:0] V_P [NV] = '{32'hFFFFFFFC, 32'hFFFFFFFC, 32'hFFFFFFFC,
        32'hFFFFFFFC, 32'hFFFFFFFC, 32'h00000001, 32'hFFFFFFFE, 32'hFFFFFFFE};
    localparam logic [31:0] V_W [NV] = '{32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE,
        32'hFFFFFFFE, 32'hFFFFFFFE, 32'h00000010, 32'hFFFFFFFF, 32'hFFFFFFFE};
    localparam int          V_N [NV] = '{0, 2, 3, 4, 5, 3, 3, 1};
    localparam logic [31:0] V_C [NV] = '{32'hFFFFFFFC, 32'hFFFFFFFE, 32'hFFFFFFFF,
        32'h00000000, 32'hFFFFFFFC, 32'h00000004, 32'hFFFFFFFE, 32'hFFFFFFFF};
    localparam logic        V_O [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    function automatic logic [8:0] mk(input int mode, input int pol, input int gate,
                                      input int src, input int trig);
        return {trig[0], src[1:0], gate[2:0], pol[0], mode[1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_period(input logic [31:0] v);
        @(negedge clk); period_wr = 1'b1; period_data = v;
        @(negedge clk); period_wr = 1'b0;
    endtask
    task automatic wr_width(input logic [31:0] v);
        @(negedge clk); width_wr = 1'b1; width_data = v;
        @(negedge clk); width_wr = 1'b0;
    endtask
    task automatic wr_ctrl(input logic [8:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_data = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic count_hi(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse_out) hi++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        int hi;
        idle(3);
        chk("R1 reset count", count_q, 32'h0);
        chk("R1 reset out", {31'b0, pulse_out}, 32'h0);
        chk("R1 reset status", {30'b0, status}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Start-register writes land while counting every cycle (R10 priority)
        wr_ctrl(mk(0, 0, 0, 0, 0));
        for (int v = 0; v < NV; v++) begin
            wr_width(V_W[v]);
            wr_period(V_P[v]);
            idle(V_N[v]);
            chk("R2/R3 count vector", count_q, V_C[v]);
            chk("R4 out vector", {31'b0, pulse_out}, {31'b0, V_O[v]});
        end

        // R4 active-low polarity
        wr_ctrl(mk(0, 1, 0, 0, 0));
        wr_width(32'hFFFFFFFE);
        wr_period(32'hFFFFFFFC);
        chk("R4 idle high", {31'b0, pulse_out}, 32'h1);
        idle(2);
        chk("R4 active low", {31'b0, pulse_out}, 32'h0);
        idle(2);
        chk("R4 terminal idle", {31'b0, pulse_out}, 32'h1);

        // R5 level gate enables counting
        wr_ctrl(mk(0, 0, 1, 0, 0));
        ext_gate_in = 1'b0; idle(5);
        wr_period(32'd50);
        idle(8);
        chk("R5 gate low holds", count_q, 32'd50);
        ext_gate_in = 1'b1; idle(5);
        a = count_q; idle(7);
        chk("R5 gate high counts", count_q, a + 32'd7);

        // R6 up/down
        wr_width(32'd1);
        wr_ctrl(mk(1, 0, 1, 0, 0));
        wr_period(32'd100);
        idle(5); a = count_q; idle(10);
        chk("R6 up", count_q, a + 32'd10);
        ext_gate_in = 1'b0; idle(5); a = count_q; idle(10);
        chk("R6 down", count_q, a - 32'd10);
        chk("R4 updn no pulse", {31'b0, pulse_out}, 32'h0);
        wr_ctrl(mk(1, 0, 2, 0, 0));
        idle(3); a = count_q; idle(10);
        chk("R6 inverted up", count_q, a + 32'd10);

        // R7 external clock source
        wr_ctrl(mk(0, 0, 0, 1, 0));
        wr_period(32'd10);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ext_clk_in = 1'b1; idle(4);
            ext_clk_in = 1'b0; idle(4);
        end
        idle(6);
        chk("R7 external ticks", count_q, 32'd14);

        // R7 cascaded source
        wr_ctrl(mk(0, 0, 0, 2, 0));
        wr_period(32'd10);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); casc_clk_in = 1'b1;
            @(negedge clk); casc_clk_in = 1'b0; idle(2);
        end
        chk("R7 cascade ticks", count_q, 32'd13);

        // R8 single shot
        ext_gate_in = 1'b0;
        wr_width(32'hFFFFFFFE);
        wr_period(32'hFFFFFFFC);
        wr_ctrl(mk(2, 0, 3, 0, 1));
        idle(5);
        chk("R8 armed idle", {30'b0, status}, 32'h1);
        chk("R8 hold while waiting", count_q, 32'hFFFFFFFC);
        @(negedge clk); ext_gate_in = 1'b1;
        count_hi(20, hi);
        chk("R8 one pulse", hi, 32'd2);
        chk("R8 disarmed", {30'b0, status}, 32'h0);
        chk("R8 reloaded", count_q, 32'hFFFFFFFC);
        ext_gate_in = 1'b0; idle(5);
        @(negedge clk); ext_gate_in = 1'b1;
        count_hi(20, hi);
        chk("R8 later gate ignored", hi, 32'd0);

        // R9 repeating shot, gate during pulse ignored
        ext_gate_in = 1'b0;
        wr_period(32'hFFFFFFF0);
        wr_ctrl(mk(3, 0, 3, 0, 1));
        idle(5);
        hi = 0;
        @(negedge clk); ext_gate_in = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i == 3) ext_gate_in = 1'b0;
            if (i == 6) ext_gate_in = 1'b1;
            if (pulse_out) hi++;
        end
        chk("R9 retrigger ignored", hi, 32'd2);
        chk("R9 stays armed", {30'b0, status}, 32'h1);
        ext_gate_in = 1'b0; idle(5);
        @(negedge clk); ext_gate_in = 1'b1;
        count_hi(40, hi);
        chk("R9 second pulse", hi, 32'd2);

        // R10 start write ends a running shot
        ext_gate_in = 1'b0; idle(5);
        @(negedge clk); ext_gate_in = 1'b1;
        idle(6);
        chk("R10 running", {30'b0, status}, 32'h3);
        wr_period(32'hFFFFFFF0);
        chk("R10 cleared by write", {30'b0, status}, 32'h1);
        chk("R10 write wins", count_q, 32'hFFFFFFF0);

        // R1 counter reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears count", count_q, 32'h0);
        chk("R1 reset clears status", {30'b0, status}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule